// File: doc/BRIEF.md
# Adaptive Prefetch Length Tuner

This block learns how many cache lines a read forwarding controller should prefetch for each of three memory read command types: plain memory read, read-line and read-multiple. Each completed burst read is reported as one event. The event carries the command type, the DWORDs that were prefetched and the DWORDs the initiator actually took. The block classifies the outcome, keeps a small signed score for that command, and moves that command's length up or down by one line when the score reaches a threshold. The three current lengths are plain outputs that the forwarding controller reads continuously.

A 2-bit mode, loaded by a configuration write strobe, selects which command types may adapt. Mode 0 freezes all three lengths at their defaults. Every configuration write restores the default lengths and clears all scores on the following clock edge, including a write of the mode already in force.

Completion events use a valid/ready handshake. `evt_ready` drops only in a cycle in which `cfg_wr` is high. A source holding `evt_valid` must keep the event fields stable until it sees `evt_ready` high at a clock edge. An event is consumed at exactly one edge: the edge where both `evt_valid` and `evt_ready` are high.

Top module: `adaptive_prefetch_tuner`

## Requirements
- R1: After reset the lengths are 1 (read), 2 (read-line) and 4 (read-multiple), the mode is 0 and `evt_ready` is high.
- R2: `evt_ready` is low in exactly the cycles in which `cfg_wr` is high. An event changes state only at an edge where `evt_valid` and `evt_ready` are both high.
- R3: A burst is "short" when used >= fetched. It is "over" when fetched - used is greater than 8 DWORDs (one line). Any other burst is "match" and leaves the score unchanged.
- R4: A short burst adds 1 to the command's score. When the score reaches +4, the length rises by one line and the score returns to 0.
- R5: An over burst subtracts 1 from the score. When the score reaches -4, the length falls by one line and the score returns to 0.
- R6: Lengths stay within 1 to 8 lines. An adjustment that would leave this range leaves the length unchanged but still clears the score.
- R7: Command encoding is 0 = read, 1 = read-line, 2 = read-multiple. Each command has its own score and length. Code 3 has no effect.
- R8: Mode 1 adapts read-multiple only. Mode 2 adapts read-line and read-multiple. Mode 3 adapts all three. Events for a command that is not enabled have no effect.
- R9: In mode 0 all lengths stay at their defaults whatever events arrive.
- R10: At the edge where `cfg_wr` is high, `cfg_mode` is loaded, every length returns to its default and every score is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Adaptation mode loaded on `cfg_wr` |
| evt_valid | input | 1 | Completion event valid |
| evt_ready | output | 1 | Completion event accepted this cycle |
| evt_cmd | input | 2 | Command type of the completed burst |
| evt_fetched | input | 8 | DWORDs prefetched for the burst |
| evt_used | input | 8 | DWORDs consumed by the initiator |
| len_mr | output | 4 | Current length in lines for plain read |
| len_mrl | output | 4 | Current length in lines for read-line |
| len_mrm | output | 4 | Current length in lines for read-multiple |

## Verification
The bench targets the "over" boundary, where exactly one line of waste must count as a match. A design that used >= there would shrink lengths too early. It drives scores that mix short and over results, so that a design adjusting on a raw count of shorts instead of a net score would step too soon. It saturates lengths at 1 and at 8, where a design with a missing clamp would wrap. It also checks that a configuration write clears partial scores: three shorts followed by a rewrite and one more short must not grow a length.

// File: rtl/pf_tune_pkg.sv
package pf_tune_pkg;

  // Command types reported on a completion event
  typedef enum logic [1:0] {
    CMD_RD    = 2'd0,
    CMD_RDLN  = 2'd1,
    CMD_RDMUL = 2'd2,
    CMD_NONE  = 2'd3
  } rd_cmd_e;

  // Classified outcome of one burst
  typedef enum logic [1:0] {
    OUT_MATCH = 2'd0,
    OUT_SHORT = 2'd1,
    OUT_OVER  = 2'd2
  } burst_out_e;

  localparam int NUM_CMD = 3;

endpackage

// File: rtl/pf_mode_decode.sv
module pf_mode_decode
  import pf_tune_pkg::*;
(
  input  logic [1:0]         mode,
  output logic [NUM_CMD-1:0] adapt_en
);

  always_comb begin
    adapt_en = '0;
    case (mode)
      2'd1:    adapt_en[CMD_RDMUL] = 1'b1;
      2'd2: begin
        adapt_en[CMD_RDLN]  = 1'b1;
        adapt_en[CMD_RDMUL] = 1'b1;
      end
      2'd3:    adapt_en = '1;
      default: adapt_en = '0;
    endcase
  end

endmodule

// File: rtl/pf_burst_classify.sv
module pf_burst_classify
  import pf_tune_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int LINE_DW = 8
) (
  input  logic [CNT_W-1:0] fetched,
  input  logic [CNT_W-1:0] used,
  output burst_out_e       outcome
);

  logic [CNT_W-1:0] waste;

  always_comb begin
    waste   = fetched - used;
    outcome = OUT_MATCH;
    if (used >= fetched) begin
      outcome = OUT_SHORT;
    end else if (waste > CNT_W'(LINE_DW)) begin
      outcome = OUT_OVER;
    end
  end

endmodule

// File: rtl/pf_len_lane.sv
module pf_len_lane
  import pf_tune_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int LEN_MIN = 1,
  parameter int LEN_MAX = 8,
  parameter int DEF_LEN = 1,
  parameter int SCORE_W = 4,
  parameter int THRESH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restore,
  input  logic             hit,
  input  burst_out_e       outcome,
  output logic [LEN_W-1:0] len
);

  localparam logic signed [SCORE_W-1:0] S_UP   = SCORE_W'(THRESH - 1);
  localparam logic signed [SCORE_W-1:0] S_DN   = -SCORE_W'(THRESH - 1);
  localparam logic signed [SCORE_W-1:0] S_TOP  = {1'b0, {(SCORE_W-1){1'b1}}};
  localparam logic signed [SCORE_W-1:0] S_BOT  = {1'b1, {(SCORE_W-1){1'b0}}};
  localparam logic [LEN_W-1:0]          L_DEF  = LEN_W'(DEF_LEN);
  localparam logic [LEN_W-1:0]          L_MAX  = LEN_W'(LEN_MAX);
  localparam logic [LEN_W-1:0]          L_MIN  = LEN_W'(LEN_MIN);

  logic signed [SCORE_W-1:0] score;

  always_ff @(posedge clk) begin
    if (!rst_n || restore) begin
      len   <= L_DEF;
      score <= '0;
    end else if (hit) begin
      case (outcome)
        OUT_SHORT: begin
          if (score == S_UP) begin
            score <= '0;
            if (len < L_MAX) len <= len + LEN_W'(1);
          end else if (score != S_TOP) begin
            score <= score + SCORE_W'(1);
          end
        end
        OUT_OVER: begin
          if (score == S_DN) begin
            score <= '0;
            if (len > L_MIN) len <= len - LEN_W'(1);
          end else if (score != S_BOT) begin
            score <= score - SCORE_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/adaptive_prefetch_tuner.sv
module adaptive_prefetch_tuner
  import pf_tune_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int LINE_DW = 8,
  parameter int LEN_MIN = 1,
  parameter int LEN_MAX = 8,
  parameter int LEN_W   = $clog2(LEN_MAX + 1),
  parameter int DEF_RD  = 1,
  parameter int DEF_RL  = 2,
  parameter int DEF_RM  = 4,
  parameter int SCORE_W = 4,
  parameter int THRESH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [1:0]       evt_cmd,
  input  logic [CNT_W-1:0] evt_fetched,
  input  logic [CNT_W-1:0] evt_used,
  output logic [LEN_W-1:0] len_mr,
  output logic [LEN_W-1:0] len_mrl,
  output logic [LEN_W-1:0] len_mrm
);

  localparam logic [NUM_CMD*LEN_W-1:0] DEF_VEC =
    {LEN_W'(DEF_RM), LEN_W'(DEF_RL), LEN_W'(DEF_RD)};

  logic [1:0]               mode_q;
  logic [NUM_CMD-1:0]       adapt_en;
  logic                     accept;
  burst_out_e               outcome;
  logic [NUM_CMD*LEN_W-1:0] len_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= 2'd0;
    else if (cfg_wr) mode_q <= cfg_mode;
  end

  assign evt_ready = !cfg_wr;
  assign accept    = evt_valid && evt_ready;

  pf_mode_decode u_mode (
    .mode     (mode_q),
    .adapt_en (adapt_en)
  );

  pf_burst_classify #(
    .CNT_W   (CNT_W),
    .LINE_DW (LINE_DW)
  ) u_class (
    .fetched (evt_fetched),
    .used    (evt_used),
    .outcome (outcome)
  );

  for (genvar gi = 0; gi < NUM_CMD; gi++) begin : g_lane
    logic hit;
    assign hit = accept && adapt_en[gi] && (evt_cmd == 2'(gi));

    pf_len_lane #(
      .LEN_W   (LEN_W),
      .LEN_MIN (LEN_MIN),
      .LEN_MAX (LEN_MAX),
      .DEF_LEN (int'(DEF_VEC[gi*LEN_W +: LEN_W])),
      .SCORE_W (SCORE_W),
      .THRESH  (THRESH)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .restore (cfg_wr),
      .hit     (hit),
      .outcome (outcome),
      .len     (len_vec[gi*LEN_W +: LEN_W])
    );
  end

  assign len_mr  = len_vec[0*LEN_W +: LEN_W];
  assign len_mrl = len_vec[1*LEN_W +: LEN_W];
  assign len_mrm = len_vec[2*LEN_W +: LEN_W];

endmodule

// File: rtl/pf_tuner_chk.sv
module pf_tuner_chk #(
  parameter int LEN_W   = 4,
  parameter int LEN_MIN = 1,
  parameter int LEN_MAX = 8,
  parameter int DEF_RD  = 1,
  parameter int DEF_RL  = 2,
  parameter int DEF_RM  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             evt_valid,
  input logic             evt_ready,
  input logic [1:0]       mode_q,
  input logic [LEN_W-1:0] len_mr,
  input logic [LEN_W-1:0] len_mrl,
  input logic [LEN_W-1:0] len_mrm
);

  // R6
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_mr >= LEN_W'(LEN_MIN) && len_mr <= LEN_W'(LEN_MAX) &&
    len_mrl >= LEN_W'(LEN_MIN) && len_mrl <= LEN_W'(LEN_MAX) &&
    len_mrm >= LEN_W'(LEN_MIN) && len_mrm <= LEN_W'(LEN_MAX));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !(evt_valid && evt_ready)) |=>
      ($stable(len_mr) && $stable(len_mrl) && $stable(len_mrm)));

  // R10
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (len_mr == LEN_W'(DEF_RD) && len_mrl == LEN_W'(DEF_RL) &&
                len_mrm == LEN_W'(DEF_RM)));

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && !cfg_wr) |=>
      ($stable(len_mr) && $stable(len_mrl) && $stable(len_mrm)));

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=>
      ((len_mr == $past(len_mr) || len_mr == $past(len_mr) + LEN_W'(1) ||
        len_mr == $past(len_mr) - LEN_W'(1)) &&
       (len_mrm == $past(len_mrm) || len_mrm == $past(len_mrm) + LEN_W'(1) ||
        len_mrm == $past(len_mrm) - LEN_W'(1))));

  // R8
  rd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd3 && !cfg_wr) |=> $stable(len_mr));

endmodule

bind adaptive_prefetch_tuner pf_tuner_chk #(
  .LEN_W   (LEN_W),
  .LEN_MIN (LEN_MIN),
  .LEN_MAX (LEN_MAX),
  .DEF_RD  (DEF_RD),
  .DEF_RL  (DEF_RL),
  .DEF_RM  (DEF_RM)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .mode_q    (mode_q),
  .len_mr    (len_mr),
  .len_mrl   (len_mrl),
  .len_mrm   (len_mrm)
);

// File: tb/adaptive_prefetch_tuner_bench.sv
`timescale 1ns/1ps
module adaptive_prefetch_tuner_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       evt_valid = 1'b0;
  logic       evt_ready;
  logic [1:0] evt_cmd = 2'd0;
  logic [7:0] evt_fetched = 8'd0;
  logic [7:0] evt_used = 8'd0;
  logic [3:0] len_mr, len_mrl, len_mrm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adaptive_prefetch_tuner u_adaptive_prefetch_tuner (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_cmd(evt_cmd),
    .evt_fetched(evt_fetched), .evt_used(evt_used),
    .len_mr(len_mr), .len_mrl(len_mrl), .len_mrm(len_mrm)
  );

  // Row: {cmd[2], fetched[8], used[8], exp_mr[4], exp_mrl[4], exp_mrm[4]}
  localparam int NROW = 24;
  localparam logic [29:0] VEC [NROW] = '{
    {2'd0, 8'd8,  8'd8, 4'd1, 4'd2, 4'd4},  // R4 short
    {2'd0, 8'd8,  8'd8, 4'd1, 4'd2, 4'd4},
    {2'd0, 8'd8,  8'd9, 4'd1, 4'd2, 4'd4},  // R3 used > fetched is short
    {2'd0, 8'd8,  8'd8, 4'd2, 4'd2, 4'd4},  // R4 reaches +4
    {2'd1, 8'd16, 8'd4, 4'd2, 4'd2, 4'd4},  // R5 over
    {2'd1, 8'd16, 8'd8, 4'd2, 4'd2, 4'd4},  // R3 exactly one line = match
    {2'd1, 8'd16, 8'd0, 4'd2, 4'd2, 4'd4},
    {2'd1, 8'd16, 8'd0, 4'd2, 4'd2, 4'd4},
    {2'd1, 8'd16, 8'd0, 4'd2, 4'd1, 4'd4},  // R5 reaches -4
    {2'd1, 8'd16, 8'd0, 4'd2, 4'd1, 4'd4},
    {2'd1, 8'd16, 8'd0, 4'd2, 4'd1, 4'd4},
    {2'd1, 8'd16, 8'd0, 4'd2, 4'd1, 4'd4},
    {2'd1, 8'd16, 8'd0, 4'd2, 4'd1, 4'd4},  // R6 floor holds at 1
    {2'd3, 8'd8,  8'd8, 4'd2, 4'd1, 4'd4},  // R7 code 3 ignored
    {2'd2, 8'd4,  8'd4, 4'd2, 4'd1, 4'd4},
    {2'd2, 8'd4,  8'd4, 4'd2, 4'd1, 4'd4},
    {2'd2, 8'd4,  8'd4, 4'd2, 4'd1, 4'd4},
    {2'd2, 8'd4,  8'd4, 4'd2, 4'd1, 4'd5},  // R7 independent lane
    {2'd0, 8'd8,  8'd8, 4'd2, 4'd1, 4'd5},
    {2'd0, 8'd8,  8'd8, 4'd2, 4'd1, 4'd5},
    {2'd0, 8'd8,  8'd8, 4'd2, 4'd1, 4'd5},
    {2'd0, 8'd20, 8'd2, 4'd2, 4'd1, 4'd5},  // R5 over cancels a short
    {2'd0, 8'd8,  8'd8, 4'd2, 4'd1, 4'd5},
    {2'd0, 8'd8,  8'd8, 4'd3, 4'd1, 4'd5}   // R4 net score reaches +4
  };

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_lens(input string tag, input int e0, input int e1, input int e2);
    check({tag, " rd"},  int'(len_mr),  e0);
    check({tag, " rl"},  int'(len_mrl), e1);
    check({tag, " rm"},  int'(len_mrm), e2);
  endtask

  task automatic send(input logic [1:0] c, input logic [7:0] f, input logic [7:0] u);
    @(negedge clk);
    evt_valid = 1'b1; evt_cmd = c; evt_fetched = f; evt_used = u;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic send_n(input int n, input logic [1:0] c, input logic [7:0] f,
                        input logic [7:0] u);
    for (int k = 0; k < n; k++) send(c, f, u);
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = m;
    #1 check("R2 ready low during cfg write", int'(evt_ready), 0);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1 check("R2 ready back high", int'(evt_ready), 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_lens("R1 reset", 1, 2, 4);
    check("R1 ready after reset", int'(evt_ready), 1);

    // R9 mode 0 frozen
    send_n(6, 2'd0, 8'd8, 8'd8);
    send_n(6, 2'd2, 8'd8, 8'd8);
    send_n(6, 2'd1, 8'd32, 8'd0);
    check_lens("R9 mode 0 frozen", 1, 2, 4);

    // Table walk in mode 3
    write_mode(2'd3);
    check_lens("R10 defaults after write", 1, 2, 4);
    for (int i = 0; i < NROW; i++) begin
      send(VEC[i][29:28], VEC[i][27:20], VEC[i][19:12]);
      check_lens($sformatf("R3/R4/R5/R7 row %0d", i),
                 int'(VEC[i][11:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]));
    end

    // R10 restore and score clear
    write_mode(2'd3);
    check_lens("R10 restore", 1, 2, 4);
    send_n(3, 2'd0, 8'd8, 8'd8);
    write_mode(2'd3);
    send(2'd0, 8'd8, 8'd8);
    check("R10 score cleared", int'(len_mr), 1);

    // R8 mode 1: only read-multiple adapts; R6 ceiling
    write_mode(2'd1);
    send_n(4, 2'd0, 8'd8, 8'd8);
    send_n(4, 2'd1, 8'd32, 8'd0);
    check("R8 mode1 rd locked", int'(len_mr), 1);
    check("R8 mode1 rl locked", int'(len_mrl), 2);
    send_n(16, 2'd2, 8'd8, 8'd8);
    check("R6 rm reaches 8", int'(len_mrm), 8);
    send_n(4, 2'd2, 8'd8, 8'd8);
    check("R6 rm ceiling", int'(len_mrm), 8);

    // R8 mode 2: read-line adapts, read does not
    write_mode(2'd2);
    send_n(4, 2'd0, 8'd8, 8'd8);
    send_n(4, 2'd1, 8'd8, 8'd8);
    check("R8 mode2 rd locked", int'(len_mr), 1);
    check("R8 mode2 rl adapts", int'(len_mrl), 3);
    check("R8 mode2 rm untouched", int'(len_mrm), 4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule